// File: doc/BRIEF.md
# Video control signal glitch filter

This block sits on the pixel-clock path ahead of a video link serializer and conditions the three low-rate control lines, data enable, horizontal sync and vertical sync, before they are carried across. Each line first passes a pulse-width qualifier that can reject glitches, and then a transition gate that limits how often the output may change. All three outputs lag their inputs by the same fixed pipeline latency, so they stay aligned with each other and with pixel data delayed by the same amount.

The qualifier is selected by a mode input and applies to data enable and horizontal sync only. The transition gate is always active. It counts changes in fixed 130-clock windows that restart at reset. A change that would exceed the budget is held back until a later window. Vertical sync gets a tighter budget and a minimum spacing between its changes.

Top module: `ctl_glitch_filter`

## Requirements
- R1: Every output follows its input with a latency of exactly 3 clocks in both modes: an input level sampled at clock edge k can first appear on the output after edge k+3.
- R2: With filtering active, a new level on de_i or hs_i reaches the output only if the input holds it for at least 3 consecutive sampled clocks. Pulses 1 or 2 clocks wide are removed completely.
- R3: With filtering inactive, de_i and hs_i pulses of any width, including 1 clock, appear on the output with their width unchanged.
- R4: Windows are fixed and consecutive. The first clock edge after reset release is edge 0 of window 0, and window n covers edges 130n to 130n+129. de_o and hs_o each change at most 2 times within a window. An extra change is dropped, the output holds its level, and it takes the pending input level at the first edge of the next window.
- R5: vs_o changes at most once per window, and two vs_o changes are always at least 130 clocks apart. vs_i is never width-qualified.
- R6: The mode input filt_en_i (1 = filtering active) is sampled at the first edge of each window and governs the whole window. Changes at other times have no effect until the next window.
- R7: While rst_ni is low, all outputs are low. Release restarts window 0 and clears the pulse-width history, the transition budgets and the vertical sync spacing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| filt_en_i | input | 1 | 1 selects pulse-width filtering for DE and HS |
| de_i | input | 1 | Raw data enable |
| hs_i | input | 1 | Raw horizontal sync |
| vs_i | input | 1 | Raw vertical sync |
| de_o | output | 1 | Conditioned data enable |
| hs_o | output | 1 | Conditioned horizontal sync |
| vs_o | output | 1 | Conditioned vertical sync |

## Verification
The pulse table sweeps widths of 1, 2, 3 and more clocks in both modes. A qualifier with an off-by-one threshold either passes 2-clock glitches or eats 3-clock pulses, and a bypass path with one register fewer shifts the first high sample off the expected edge. A directed budget case makes a third DE change in one window and holds it: a gate that never blocks lets it through at once, and one that forgets to reopen keeps the output low past the window boundary. The vertical sync case checks that the falling edge is delayed to exactly 130 clocks after the rise. The mode case flips filt_en_i mid-window and expects a 1-clock pulse to pass in that window and be rejected in the next. A design that applies the mode at once would reject the first pulse.

// File: rtl/ctl_filter_pkg.sv
package ctl_filter_pkg;
  typedef enum logic [1:0] {
    CH_DE = 2'd0,
    CH_HS = 2'd1,
    CH_VS = 2'd2
  } ctl_ch_e;

  localparam int unsigned NUM_CH = 3;

  function automatic bit ch_is_qualified(input int unsigned ch);
    return ch != int'(CH_VS);
  endfunction
endpackage

// File: rtl/ctl_window_timer.sv
module ctl_window_timer #(
  parameter int unsigned WIN_LEN = 130
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic filt_en_i,
  output logic win_last_o,
  output logic mode_o
);
  localparam int unsigned CW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN_LEN - 1);

  logic [CW-1:0] cnt_q;
  logic          mode_q;
  logic          win_first;

  assign win_first  = (cnt_q == '0);
  assign win_last_o = (cnt_q == LAST);
  // mode is live on the first edge of a window, then frozen
  assign mode_o     = win_first ? filt_en_i : mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      cnt_q  <= win_last_o ? '0 : cnt_q + 1'b1;
      mode_q <= mode_o;
    end
  end
endmodule

// File: rtl/ctl_width_qual.sv
module ctl_width_qual #(
  parameter int unsigned DEPTH   = 3,
  parameter bit          QUAL_EN = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic mode_i,
  input  logic cur_i,
  output logic want_o
);
  logic [DEPTH-1:0] sh_q;
  logic             steady;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[DEPTH-2:0], raw_i};
  end

  assign steady = (&sh_q) | ~(|sh_q);

  generate
    if (QUAL_EN) begin : g_qual
      // unsteady history keeps the present output level
      assign want_o = (mode_i && !steady) ? cur_i : sh_q[DEPTH-1];
    end else begin : g_pass
      logic unused_w;
      assign unused_w = mode_i ^ cur_i ^ steady;
      assign want_o   = sh_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/ctl_budget_gate.sv
module ctl_budget_gate #(
  parameter int unsigned LIMIT   = 2,
  parameter int unsigned MIN_GAP = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic want_i,
  input  logic win_last_i,
  output logic out_o
);
  localparam int unsigned UW = $clog2(LIMIT + 1);

  logic [UW-1:0] used_q;
  logic          gap_ok;
  logic          fire;

  assign fire = (want_i != out_o) && (used_q < UW'(LIMIT)) && gap_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_o  <= 1'b0;
      used_q <= '0;
    end else begin
      if (fire) out_o <= want_i;
      if (win_last_i) used_q <= '0;
      else if (fire)  used_q <= used_q + 1'b1;
    end
  end

  generate
    if (MIN_GAP > 1) begin : g_gap
      localparam int unsigned HW = $clog2(MIN_GAP);
      logic [HW-1:0] hold_q;
      assign gap_ok = (hold_q == '0);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            hold_q <= '0;
        else if (fire)          hold_q <= HW'(MIN_GAP - 1);
        else if (hold_q != '0)  hold_q <= hold_q - 1'b1;
      end
    end else begin : g_nogap
      assign gap_ok = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/ctl_glitch_filter.sv
module ctl_glitch_filter
  import ctl_filter_pkg::*;
#(
  parameter int unsigned WIN_LEN    = 130,
  parameter int unsigned MIN_PULSE  = 3,
  parameter int unsigned PAIR_LIMIT = 2,
  parameter int unsigned VS_LIMIT   = 1,
  parameter int unsigned VS_MIN_GAP = 130
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic filt_en_i,
  input  logic de_i,
  input  logic hs_i,
  input  logic vs_i,
  output logic de_o,
  output logic hs_o,
  output logic vs_o
);
  logic              win_last;
  logic              mode;
  logic [NUM_CH-1:0] raw;
  logic [NUM_CH-1:0] want;
  logic [NUM_CH-1:0] cur;

  assign raw = {vs_i, hs_i, de_i};

  ctl_window_timer #(.WIN_LEN(WIN_LEN)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .filt_en_i (filt_en_i),
    .win_last_o(win_last),
    .mode_o    (mode)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam bit          QUAL = ch_is_qualified(c);
    localparam int unsigned LIM  = QUAL ? PAIR_LIMIT : VS_LIMIT;
    localparam int unsigned GAP  = QUAL ? 0 : VS_MIN_GAP;

    ctl_width_qual #(.DEPTH(MIN_PULSE), .QUAL_EN(QUAL)) u_qual (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (raw[c]),
      .mode_i(mode),
      .cur_i (cur[c]),
      .want_o(want[c])
    );

    ctl_budget_gate #(.LIMIT(LIM), .MIN_GAP(GAP)) u_gate (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .want_i    (want[c]),
      .win_last_i(win_last),
      .out_o     (cur[c])
    );
  end

  assign de_o = cur[CH_DE];
  assign hs_o = cur[CH_HS];
  assign vs_o = cur[CH_VS];
endmodule

// File: rtl/ctl_glitch_filter_chk.sv
module ctl_glitch_filter_chk #(
  parameter int unsigned WIN_LEN    = 130,
  parameter int unsigned PAIR_LIMIT = 2,
  parameter int unsigned VS_LIMIT   = 1,
  parameter int unsigned VS_MIN_GAP = 130
) (
  input logic clk_i,
  input logic rst_ni,
  input logic de_i,
  input logic hs_i,
  input logic vs_i,
  input logic de_o,
  input logic hs_o,
  input logic vs_o
);
  localparam int unsigned CW = $clog2(WIN_LEN);

  logic [2:0]    since_q;
  logic [CW-1:0] cc_q, cc_d;
  logic          de_l, hs_l, vs_l;
  logic [3:0]    de_tc, hs_tc, vs_tc, de_n, hs_n, vs_n;
  logic [7:0]    vs_gap;
  logic          de_t, hs_t, vs_t;

  assign de_t = de_o != de_l;
  assign hs_t = hs_o != hs_l;
  assign vs_t = vs_o != vs_l;
  assign de_n = ((cc_d == '0) ? 4'd0 : de_tc) + {3'd0, de_t};
  assign hs_n = ((cc_d == '0) ? 4'd0 : hs_tc) + {3'd0, hs_t};
  assign vs_n = ((cc_d == '0) ? 4'd0 : vs_tc) + {3'd0, vs_t};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q <= '0;
      cc_q <= '0; cc_d <= '0;
      de_l <= 1'b0; hs_l <= 1'b0; vs_l <= 1'b0;
      de_tc <= '0; hs_tc <= '0; vs_tc <= '0;
      vs_gap <= 8'hff;
    end else begin
      if (since_q != 3'd7) since_q <= since_q + 1'b1;
      cc_q <= (cc_q == CW'(WIN_LEN - 1)) ? '0 : cc_q + 1'b1;
      cc_d <= cc_q;
      de_l <= de_o; hs_l <= hs_o; vs_l <= vs_o;
      de_tc <= de_n; hs_tc <= hs_n; vs_tc <= vs_n;
      if (vs_t)                 vs_gap <= 8'd1;
      else if (vs_gap != 8'hff) vs_gap <= vs_gap + 1'b1;
    end
  end

  a_r1_de_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q >= 3'd4 && de_t) |-> de_o == $past(de_i, 4));
  a_r1_hs_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q >= 3'd4 && hs_t) |-> hs_o == $past(hs_i, 4));
  a_r1_vs_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q >= 3'd4 && vs_t) |-> vs_o == $past(vs_i, 4));
  a_r4_de_budget: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_n <= 4'(PAIR_LIMIT));
  a_r4_hs_budget: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_n <= 4'(PAIR_LIMIT));
  a_r5_vs_budget: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_n <= 4'(VS_LIMIT));
  a_r5_vs_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_t |-> vs_gap >= 8'(VS_MIN_GAP));
  a_r7_reset_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!de_o && !hs_o && !vs_o));
endmodule

bind ctl_glitch_filter ctl_glitch_filter_chk #(
  .WIN_LEN(WIN_LEN), .PAIR_LIMIT(PAIR_LIMIT),
  .VS_LIMIT(VS_LIMIT), .VS_MIN_GAP(VS_MIN_GAP)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .de_i(de_i), .hs_i(hs_i), .vs_i(vs_i),
  .de_o(de_o), .hs_o(hs_o), .vs_o(vs_o)
);

// File: tb/tb_ctl_glitch_filter.sv
`timescale 1ns/1ps
module tb_ctl_glitch_filter;
  localparam int WIN = 130;
  localparam int NV  = 10;
  // {filt, sel_hs, width[3:0], pass}
  localparam logic [6:0] VEC [NV] = '{
    {1'b0, 1'b0, 4'd1, 1'b1}, {1'b0, 1'b0, 4'd2, 1'b1},
    {1'b0, 1'b1, 4'd1, 1'b1}, {1'b1, 1'b0, 4'd1, 1'b0},
    {1'b1, 1'b0, 4'd2, 1'b0}, {1'b1, 1'b0, 4'd3, 1'b1},
    {1'b1, 1'b1, 4'd2, 1'b0}, {1'b1, 1'b1, 4'd3, 1'b1},
    {1'b1, 1'b1, 4'd6, 1'b1}, {1'b0, 1'b1, 4'd4, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic filt_en = 1'b1;
  logic de = 1'b0, hs = 1'b0, vs = 1'b0;
  logic de_q, hs_q, vs_q;
  int edge_n = -1;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  ctl_glitch_filter dut (
    .clk_i(clk), .rst_ni(rst_n), .filt_en_i(filt_en),
    .de_i(de), .hs_i(hs), .vs_i(vs),
    .de_o(de_q), .hs_o(hs_q), .vs_o(vs_q)
  );

  always #2 clk = ~clk;
  always @(posedge clk) edge_n = rst_n ? edge_n + 1 : -1;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, edge_n);
    end
  endtask

  // return at the falling edge that follows clock edge k
  task automatic wait_after(input int k);
    do @(negedge clk); while (edge_n < k);
  endtask

  function automatic int next_win();
    return ((edge_n / WIN) + 2) * WIN;
  endfunction

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run completion)");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n0;
    repeat (3) @(negedge clk);
    chk("R7 reset de", de_q, 0);
    chk("R7 reset vs", vs_q, 0);
    rst_n = 1'b1;
    // R1: all three aligned, filter active
    wait_after(4);
    de = 1'b1; hs = 1'b1; vs = 1'b1;
    wait_after(7);
    chk("R1 de early", de_q, 0);
    wait_after(8);
    chk("R1 de", de_q, 1);
    chk("R1 hs", hs_q, 1);
    chk("R1 vs", vs_q, 1);
    rst_n = 1'b0; de = 1'b0; hs = 1'b0; vs = 1'b0;
    #1;
    chk("R7 async de", de_q, 0);
    chk("R7 async hs", hs_q, 0);
    chk("R7 async vs", vs_q, 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;

    // R2/R3 pulse table
    for (int v = 0; v < NV; v++) begin
      int w, first, cnt;
      logic sel;
      n0 = next_win();
      wait_after(n0 - 1);
      filt_en = VEC[v][6];
      sel = VEC[v][5];
      w = int'(VEC[v][4:1]);
      first = -1; cnt = 0;
      for (int j = n0; j <= n0 + 20; j++) begin
        logic lvl, o;
        wait_after(j);
        o = sel ? hs_q : de_q;
        if (o) begin
          cnt++;
          if (first < 0) first = j - n0;
        end
        lvl = (j + 1 >= n0 + 5) && (j + 1 < n0 + 5 + w);
        if (sel) hs = lvl; else de = lvl;
      end
      if (VEC[v][6]) chk($sformatf("R2 width v%0d", v), cnt, VEC[v][0] ? w : 0);
      else           chk($sformatf("R3 width v%0d", v), cnt, w);
      chk($sformatf("R1 start v%0d", v), first, VEC[v][0] ? 8 : -1);
    end

    // R4: third DE change in a window waits for the next window
    n0 = next_win();
    wait_after(n0 - 1);
    filt_en = 1'b0;
    wait_after(n0 + 4);  de = 1'b1;
    wait_after(n0 + 9);  de = 1'b0;
    wait_after(n0 + 12); chk("R4 rise", de_q, 1);
    wait_after(n0 + 13); chk("R4 fall", de_q, 0);
    wait_after(n0 + 14); de = 1'b1;
    wait_after(n0 + 20); chk("R4 blocked", de_q, 0);
    wait_after(n0 + 129); chk("R4 held", de_q, 0);
    wait_after(n0 + 130); chk("R4 reopened", de_q, 1);
    de = 1'b0;

    // R5: VS fall held until 130 clocks after its rise
    n0 = next_win();
    wait_after(n0 + 4);  vs = 1'b1;
    wait_after(n0 + 8);  chk("R5 vs rise", vs_q, 1);
    wait_after(n0 + 14); vs = 1'b0;
    wait_after(n0 + 20); chk("R5 vs held", vs_q, 1);
    wait_after(n0 + 137); chk("R5 vs gap", vs_q, 1);
    wait_after(n0 + 138); chk("R5 vs fall", vs_q, 0);

    // R6: mode change mid-window waits for the boundary
    n0 = next_win();
    wait_after(n0 - 1);  filt_en = 1'b0;
    wait_after(n0 + 1);  filt_en = 1'b1;
    wait_after(n0 + 4);  de = 1'b1;
    wait_after(n0 + 5);  de = 1'b0;
    wait_after(n0 + 8);  chk("R6 old mode", de_q, 1);
    wait_after(n0 + 9);  chk("R6 old mode end", de_q, 0);
    wait_after(n0 + 134); de = 1'b1;
    wait_after(n0 + 135); de = 1'b0;
    wait_after(n0 + 138); chk("R6 new mode", de_q, 0);
    wait_after(n0 + 140); chk("R6 new mode late", de_q, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule